// File: doc/BRIEF.md
# Data-Space Addressing and Bit Set/Clear/Test Unit

This unit sits beside the core of a small 8-bit controller. It turns an instruction's addressing information into the byte address of a 256-entry data memory, and it runs single-bit operations on the byte found there. A command is given as a one-cycle start pulse. With it come a two-bit mode, the opcode byte and the byte that follows the opcode. Byte commands either store a supplied value at the resolved address or simply present that address for a read. Bit commands read the target byte and then either write it back with one bit forced to 1 or 0, or only report the bit.

The unit keeps private copies of the two pointer registers that live in the data memory at 80h and 81h. Every write the unit makes to either location also refreshes the matching copy, so the next indirect access uses the new pointer. The memory port is synchronous: read data appears one cycle after the address is presented.

Top module: `dsbit_unit`

## Requirements
- R1: After reset, busy, done, memWe, carry and testBit are 0, and both pointer copies are 00h, so an indirect command resolves to address 00h.
- R2: With mode 00 (direct), the effective address equals the operand byte.
- R3: With mode 01 (short direct), the effective address is 80h plus opcode bits 1:0, and the other opcode bits are ignored.
- R4: With mode 10 (indirect), the effective address is the X pointer copy when opcode bit 4 is 0 and the Y pointer copy when it is 1.
- R5: With mode 11 (bit direct), the effective address is the operand byte and opcode bits 7:5 select the bit. When opcode bit 3 is 0, the byte is written back with only that bit changed: set when opcode bit 4 is 1, cleared when it is 0.
- R6: A bit set or clear loads carry with the value the selected bit held before the write. The carry is updated even when the bit already had the target value.
- R7: A bit-direct command with opcode bit 3 set is a test. It drives the selected bit onto testBit, performs no memory write and leaves carry unchanged. testBit keeps its value until the next test.
- R8: Any write to 80h updates the X copy and any write to 81h updates the Y copy. This holds for byte stores and for bit set/clear, and a later indirect command uses the new value.
- R9: A byte command writes (if storeEn) in the cycle after start and raises done one cycle later. A set or clear writes in the second cycle after start and raises done one cycle later. done is a one-cycle pulse, and start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command (only when not busy) |
| mode | input | 2 | 00 direct, 01 short direct, 10 indirect, 11 bit direct |
| opcode | input | 8 | Opcode byte of the instruction |
| operand | input | 8 | Byte following the opcode (address for direct and bit direct) |
| storeEn | input | 1 | Byte command writes storeData instead of only addressing |
| storeData | input | 8 | Value written by a byte store |
| memRdata | input | 8 | Synchronous read data from the data memory |
| effAddr | output | 8 | Resolved data-space address, drives the memory |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 8 | Byte written (store value or modified byte) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| carry | output | 1 | Original value of the last set/cleared bit |
| testBit | output | 1 | Value of the last tested bit |

## Verification
The bench sets a bit that is already 1 and clears a bit that is already 0. A unit that skips the write or the carry load in those cases leaves carry stale. It writes pointer 81h with a bit operation and 80h with a store, then reads indirectly through each. A unit whose pointer copies do not track those writes resolves the old address. It also checks the corner cases below:
- Tests leave memory and carry alone. A unit that writes on a test shows up in the write count.
- A second start raised during a running command is ignored. A unit that accepts it corrupts an unrelated byte.
- Short-direct decoding uses only the low opcode bits. An all-ones opcode must still give 83h.

// File: rtl/dsbit_pkg.sv
package dsbit_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_SHORT    = 2'b01,
    MODE_INDIRECT = 2'b10,
    MODE_BIT      = 2'b11
  } amode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;   // capture command fields
    logic accessCyc;  // address phase (read issue / byte store)
    logic modifyCyc;  // write-back phase of a bit command
  } dpStrobe_t;

endpackage

// File: rtl/dsbit_ctrl.sv
module dsbit_ctrl
  import dsbit_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cmdIsBit,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      done
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_MODIFY} state_e;
  state_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:   if (start) state <= ST_ACCESS;
        ST_ACCESS: begin
          if (cmdIsBit) state <= ST_MODIFY;
          else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_MODIFY: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchCmd  = (state == ST_IDLE) && start;
    strb.accessCyc = (state == ST_ACCESS);
    strb.modifyCyc = (state == ST_MODIFY);
    busy           = (state != ST_IDLE);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_MODIFY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MODIFY) |-> $past(state == ST_ACCESS)); // R9

endmodule

// File: rtl/dsbit_datapath.sv
module dsbit_datapath
  import dsbit_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_SHORT = 4,
  parameter logic [DATA_W-1:0] REG_BASE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  amode_e            mode,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic              storeEn,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] effAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              carry,
  output logic              testBit,
  output logic              cmdIsBit
);

  localparam int BIT_IDX_W   = $clog2(DATA_W);
  localparam int SHORT_SEL_W = $clog2(NUM_SHORT);
  localparam int OP_SET_POS  = 4;
  localparam int OP_TEST_POS = 3;
  localparam int OP_PTR_POS  = 4;

  amode_e            modeQ;
  logic [DATA_W-1:0] opQ, operandQ, dataQ;
  logic              storeQ;
  logic [DATA_W-1:0] ptrX, ptrY;

  logic                 isTest, setNotClr;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [DATA_W-1:0]    bitMask, modByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_DIRECT;
      opQ      <= '0;
      operandQ <= '0;
      dataQ    <= '0;
      storeQ   <= 1'b0;
    end else if (strb.latchCmd) begin
      modeQ    <= mode;
      opQ      <= opcode;
      operandQ <= operand;
      dataQ    <= storeData;
      storeQ   <= storeEn;
    end
  end

  always_comb begin
    cmdIsBit  = (modeQ == MODE_BIT);
    isTest    = cmdIsBit && opQ[OP_TEST_POS];
    setNotClr = opQ[OP_SET_POS];
    bitIdx    = opQ[DATA_W-1 -: BIT_IDX_W];
    bitMask   = DATA_W'(1) << bitIdx;
    modByte   = setNotClr ? (memRdata | bitMask) : (memRdata & ~bitMask);
  end

  always_comb begin
    case (modeQ)
      MODE_SHORT:    effAddr = REG_BASE + DATA_W'(opQ[SHORT_SEL_W-1:0]);
      MODE_INDIRECT: effAddr = opQ[OP_PTR_POS] ? ptrY : ptrX;
      default:       effAddr = operandQ;
    endcase
  end

  always_comb begin
    memWe    = (strb.accessCyc && !cmdIsBit && storeQ) ||
               (strb.modifyCyc && cmdIsBit && !isTest);
    memWdata = cmdIsBit ? modByte : dataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrX    <= '0;
      ptrY    <= '0;
      carry   <= 1'b0;
      testBit <= 1'b0;
    end else begin
      if (memWe && effAddr == REG_BASE)              ptrX <= memWdata;
      if (memWe && effAddr == REG_BASE + DATA_W'(1)) ptrY <= memWdata;
      if (strb.modifyCyc && cmdIsBit && !isTest)     carry   <= memRdata[bitIdx];
      if (strb.modifyCyc && isTest)                  testBit <= memRdata[bitIdx];
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (strb.accessCyc || strb.modifyCyc)); // R9

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modifyCyc && isTest) |-> !memWe); // R7

  AST_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && strb.modifyCyc) |-> ($countones(memWdata ^ memRdata) <= 1)); // R5

  AST_PTR_X_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && effAddr == REG_BASE) |=> (ptrX == $past(memWdata))); // R8

  AST_CARRY_HELD_ON_TEST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modifyCyc && isTest) |=> $stable(carry)); // R7

endmodule

// File: rtl/dsbit_unit.sv
module dsbit_unit
  import dsbit_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_SHORT = 4,
  parameter logic [DATA_W-1:0] REG_BASE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic              storeEn,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] effAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              busy,
  output logic              done,
  output logic              carry,
  output logic              testBit
);

  dpStrobe_t strb;
  logic      cmdIsBit;

  dsbit_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdIsBit (cmdIsBit),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  dsbit_datapath #(
    .DATA_W    (DATA_W),
    .NUM_SHORT (NUM_SHORT),
    .REG_BASE  (REG_BASE)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .mode      (amode_e'(mode)),
    .opcode    (opcode),
    .operand   (operand),
    .storeEn   (storeEn),
    .storeData (storeData),
    .memRdata  (memRdata),
    .effAddr   (effAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .carry     (carry),
    .testBit   (testBit),
    .cmdIsBit  (cmdIsBit)
  );

endmodule

// File: tb/test_dsbit_unit.sv
`timescale 1ns/1ps
module test_dsbit_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] opcode = '0, operand = '0, storeData = '0;
  logic       storeEn = 1'b0;
  logic [7:0] memRdata;
  logic [7:0] effAddr, memWdata;
  logic       memWe, busy, done, carry, testBit;

  int testsRun = 0;
  int testsFailed = 0;
  int weCount = 0;

  always #4 clk = ~clk;

  dsbit_unit i_dsbit_unit (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .opcode(opcode),
    .operand(operand), .storeEn(storeEn), .storeData(storeData),
    .memRdata(memRdata), .effAddr(effAddr), .memWe(memWe),
    .memWdata(memWdata), .busy(busy), .done(done), .carry(carry),
    .testBit(testBit)
  );

  // bench-owned data memory, synchronous read
  logic [7:0] mem [256];
  logic       preWe = 1'b0;
  logic [7:0] preAddr = '0, preData = '0;
  always @(posedge clk) begin
    if (preWe) mem[preAddr] <= preData;
    else if (memWe) mem[effAddr] <= memWdata;
    memRdata <= mem[effAddr];
    if (memWe) weCount <= weCount + 1;
  end

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] op;
    logic [7:0] opnd;
    logic       st;
    logic [7:0] sd;
    logic [7:0] expAddr;
    logic [7:0] expByte;
    logic       expCarry;
    logic       expTest;
    logic [1:0] expWrites;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{2'd3, 8'h30, 8'h40, 1'b0, 8'h00, 8'h40, 8'hA7, 1'b0, 1'b0, 2'd1},
    '{2'd3, 8'hE0, 8'h40, 1'b0, 8'h00, 8'h40, 8'h27, 1'b1, 1'b0, 2'd1},
    '{2'd3, 8'hA8, 8'h40, 1'b0, 8'h00, 8'h40, 8'h27, 1'b1, 1'b1, 2'd0},
    '{2'd0, 8'h00, 8'h80, 1'b1, 8'h55, 8'h80, 8'h55, 1'b1, 1'b1, 2'd1},
    '{2'd1, 8'h01, 8'h00, 1'b1, 8'h10, 8'h81, 8'h10, 1'b1, 1'b1, 2'd1},
    '{2'd2, 8'h10, 8'h00, 1'b0, 8'h00, 8'h10, 8'h0F, 1'b1, 1'b1, 2'd0},
    '{2'd2, 8'h00, 8'h00, 1'b1, 8'hC3, 8'h55, 8'hC3, 1'b1, 1'b1, 2'd1},
    '{2'd3, 8'h10, 8'h81, 1'b0, 8'h00, 8'h81, 8'h11, 1'b0, 1'b1, 2'd1},
    '{2'd2, 8'h10, 8'h00, 1'b0, 8'h00, 8'h11, 8'h00, 1'b0, 1'b1, 2'd0},
    '{2'd1, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h83, 8'h00, 1'b0, 1'b1, 2'd0},
    '{2'd3, 8'h70, 8'h10, 1'b0, 8'h00, 8'h10, 8'h0F, 1'b1, 1'b1, 2'd1},
    '{2'd3, 8'hC0, 8'h10, 1'b0, 8'h00, 8'h10, 8'h0F, 1'b0, 1'b1, 2'd1},
    '{2'd3, 8'h88, 8'h10, 1'b0, 8'h00, 8'h10, 8'h0F, 1'b0, 1'b0, 2'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    preWe = 1'b1; preAddr = a; preData = d;
    @(negedge clk);
    preWe = 1'b0;
  endtask

  // issue one command; returns address seen in the access cycle,
  // negedges until done, and writes performed
  task automatic runCmd(input logic [1:0] md, input logic [7:0] op,
                        input logic [7:0] opnd, input logic st, input logic [7:0] sd,
                        output logic [7:0] gotAddr, output int cyc, output int wr);
    int weStart;
    @(negedge clk);
    mode = md; opcode = op; operand = opnd; storeEn = st; storeData = sd;
    start = 1'b1;
    weStart = weCount;
    @(negedge clk);
    start = 1'b0;
    gotAddr = effAddr;
    cyc = 1;
    while (!done && cyc < 10) begin
      @(negedge clk);
      cyc++;
    end
    wr = weCount - weStart;
  endtask

  initial begin
    #200000;
    testsFailed++;
    $display("FAIL R9: watchdog expired, actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] a;
    int cyc, wr;
    string req;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !memWe, "R1 idle after reset", {busy, done, memWe}, 0);
    check(carry == 1'b0 && testBit == 1'b0, "R1 flags after reset", {carry, testBit}, 0);

    poke(8'h40, 8'hA5);
    poke(8'h10, 8'h0F);

    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v].md)
        2'd0: req = "R2";
        2'd1: req = "R3";
        2'd2: req = "R4";
        default: req = "R5";
      endcase
      runCmd(VEC[v].md, VEC[v].op, VEC[v].opnd, VEC[v].st, VEC[v].sd, a, cyc, wr);
      check(a == VEC[v].expAddr, {req, " address"}, a, VEC[v].expAddr);
      check(cyc == ((VEC[v].md == 2'd3) ? 3 : 2), "R9 done timing", cyc,
            (VEC[v].md == 2'd3) ? 3 : 2);
      check(wr == int'(VEC[v].expWrites), "R7 write count", wr, VEC[v].expWrites);
      check(mem[VEC[v].expAddr] == VEC[v].expByte, "R5 R8 memory byte",
            mem[VEC[v].expAddr], VEC[v].expByte);
      check(carry == VEC[v].expCarry, "R6 carry", carry, VEC[v].expCarry);
      check(testBit == VEC[v].expTest, "R7 testBit", testBit, VEC[v].expTest);
    end

    // R9 start while busy is ignored
    @(negedge clk);
    mode = 2'd3; opcode = 8'h70; operand = 8'h40; storeEn = 1'b0; start = 1'b1;
    @(negedge clk);
    mode = 2'd0; opcode = 8'h00; operand = 8'h20; storeEn = 1'b1; storeData = 8'hEE;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; storeEn = 1'b0;
    repeat (3) @(negedge clk);
    check(mem[8'h20] == 8'h00, "R9 start ignored while busy", mem[8'h20], 8'h00);
    check(mem[8'h40] == 8'h2F, "R9 first command completed", mem[8'h40], 8'h2F);
    check(!busy, "R9 idle afterwards", busy, 0);

    // R1 pointer copies reset
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    runCmd(2'd2, 8'h00, 8'h00, 1'b0, 8'h00, a, cyc, wr);
    check(a == 8'h00, "R1 X pointer reset", a, 8'h00);
    runCmd(2'd2, 8'h10, 8'h00, 1'b0, 8'h00, a, cyc, wr);
    check(a == 8'h00, "R1 Y pointer reset", a, 8'h00);
    check(carry == 1'b0, "R1 carry reset", carry, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule